// File: doc/BRIEF.md
# Barrel-Interleaved Multi-Context Execution Engine

This block runs eight independent instruction streams, called contexts, on one short pipeline. Each context keeps its own program counter and its own bank of sixteen 32-bit registers. A slot counter steps through the contexts in a fixed ring, and each clock offers the fetch port to the context whose slot it is. There are four stages, so a context's next instruction enters only after its previous one has written back. For that reason the pipeline needs no bypass network and no stall logic.

A small register-to-register subset is executed in hardware. Any other opcode is not executed. The context that issued it is frozen in place, and a handoff request goes out on a valid/ready port to a software host. The request names one of two host tiers: a full-system tier for I/O-class opcodes, and a nearer instruction emulator for everything else. A frozen context's slot keeps turning, but it issues nothing, so the other contexts go on unaffected. When the host has finished, it uses the resume port to write at most one register and set the next PC. The context then rejoins the ring. Every instruction that executes is reported on a retire port.

Top module: `ilv_engine`

## Requirements
- R1: The slot counter is 0 after reset and goes up by one every cycle, wrapping from 7 to 0. In each cycle `fetchCtx` equals the slot, and `fetchPc` is that context's PC. `fetchValid` is high exactly when that context is not parked.
- R2: An instruction fetched in cycle t appears on the retire port in cycle t+3. Its register result is visible to the next instruction of the same context without any stall.
- R3: The instruction word splits as opcode [15:12], rd [11:8], rs1 [7:4], rs2/imm [3:0]. Opcode 0 writes rs1+rs2, 1 writes rs1-rs2, 2 writes rs1&rs2, 3 writes rs1|rs2, and 4 writes rs1 plus the zero-extended imm. Each of these then advances the PC by one.
- R4: Opcode 5 writes no register. If rs1 is zero, the PC becomes PC plus the sign-extended 4-bit field [3:0]. Otherwise the PC becomes PC+1.
- R5: Any other opcode writes no register and does not retire. Its context is parked with its PC left unchanged. Its slot then shows `fetchValid` low, and the other contexts keep issuing.
- R6: Each parked context raises one handoff request carrying its context number, its PC and the instruction word. `reqTier` is 1 for opcode 14 and 0 for every other opcode. When several requests wait, the lowest context number is offered first. The offered request holds steady until `reqReady` is seen high.
- R7: A resume is applied only to a context that is parked and whose request has been accepted. It sets that context's PC to `rsmNextPc` and, when `rsmWrEn` is high, writes `rsmWrData` into register `rsmWrIdx`. The context issues again from its next slot. A resume aimed at any other context changes nothing.
- R8: A synchronous active-low reset clears all PCs and registers, leaves every context runnable and clears all requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| fetchValid | output | 1 | The current slot fetches an instruction |
| fetchCtx | output | 3 | Context owning the current slot |
| fetchPc | output | 16 | Word address being fetched |
| fetchInstr | input | 16 | Instruction word for fetchPc, returned in the same cycle |
| retireValid | output | 1 | An executed instruction completes |
| retireCtx | output | 3 | Context of the completing instruction |
| retirePc | output | 16 | PC of the completing instruction |
| retireWrEn | output | 1 | A register is written |
| retireIdx | output | 4 | Destination register |
| retireData | output | 32 | Value written |
| reqValid | output | 1 | Handoff request offered |
| reqReady | input | 1 | Host takes the request |
| reqCtx | output | 3 | Parked context |
| reqPc | output | 16 | PC of the unsupported instruction |
| reqInstr | output | 16 | The unsupported instruction word |
| reqTier | output | 1 | 1 = full-system tier, 0 = emulator tier |
| rsmValid | input | 1 | Resume strobe |
| rsmCtx | input | 3 | Context to resume |
| rsmWrEn | input | 1 | Apply the register write |
| rsmWrIdx | input | 4 | Register to write |
| rsmWrData | input | 32 | Value to write |
| rsmNextPc | input | 16 | PC to continue from |

## Verification
The embedded properties assume that `fetchInstr` is always a defined word for whatever address is fetched. They also assume the host's resume targets differ from the context that is trapping in the same cycle; this follows from the fact that a trapping context is never already parked. The stimulus keeps to this with a program image that is filled entirely, and with resume strobes aimed only at contexts whose park state the bench already knows. The bench deliberately holds `reqReady` low for several cycles while two requests are waiting, so that the steadiness and lowest-first ordering of the request port are exercised. It also sends one resume to a running context to show that such a resume is dropped.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int NUM_CTX    = 8;
  localparam int NUM_STAGES = 4;
  localparam int NUM_REGS   = 16;
  localparam int DATA_W     = 32;
  localparam int INSTR_W    = 16;
  localparam int PC_W       = 16;
  localparam int CTX_W      = $clog2(NUM_CTX);
  localparam int REG_W      = $clog2(NUM_REGS);
  localparam int OPC_W      = 4;
  localparam int IMM_W      = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_ADDI = 4'd4,
    OP_BEQZ = 4'd5,
    OP_IO   = 4'd14,
    OP_EMU  = 4'd15
  } opcode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             issue;
    logic [CTX_W-1:0] issueCtx;
    logic             resume;
    logic [CTX_W-1:0] resumeCtx;
    logic [CTX_W-1:0] reqCtx;
  } ctrl_t;

  // writeback-stage trap report from datapath to control
  typedef struct packed {
    logic             park;
    logic [CTX_W-1:0] parkCtx;
    logic             parkTier;
  } trap_t;
endpackage

// File: rtl/ilv_control.sv
module ilv_control
  import ilv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  trap_t            trapIn,
  input  logic             reqReady,
  input  logic             rsmValid,
  input  logic [CTX_W-1:0] rsmCtx,
  output ctrl_t            ctrl,
  output logic             reqValid,
  output logic             reqTier
);
  logic [CTX_W-1:0]   slot;
  logic [NUM_CTX-1:0] parked, pending, tierBit;
  logic               reqActive;
  logic [CTX_W-1:0]   reqCur;
  logic [CTX_W-1:0]   pickCtx;
  logic               pickAny;
  logic               handshake, resumeOk;

  always_comb begin
    pickAny = 1'b0;
    pickCtx = '0;
    for (int i = NUM_CTX - 1; i >= 0; i--) begin
      if (pending[i]) begin
        pickAny = 1'b1;
        pickCtx = CTX_W'(i);
      end
    end
  end

  assign handshake = reqActive && reqReady;
  assign resumeOk  = rsmValid && parked[rsmCtx] && !pending[rsmCtx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slot      <= '0;
      parked    <= '0;
      pending   <= '0;
      tierBit   <= '0;
      reqActive <= 1'b0;
      reqCur    <= '0;
    end else begin
      slot <= (slot == CTX_W'(NUM_CTX - 1)) ? '0 : slot + 1'b1;
      if (trapIn.park) begin
        parked[trapIn.parkCtx]  <= 1'b1;
        pending[trapIn.parkCtx] <= 1'b1;
        tierBit[trapIn.parkCtx] <= trapIn.parkTier;
      end
      if (resumeOk) parked[rsmCtx] <= 1'b0;
      if (handshake) begin
        pending[reqCur] <= 1'b0;
        reqActive       <= 1'b0;
      end else if (!reqActive && pickAny) begin
        reqActive <= 1'b1;
        reqCur    <= pickCtx;
      end
    end
  end

  always_comb begin
    ctrl.issue     = !parked[slot];
    ctrl.issueCtx  = slot;
    ctrl.resume    = resumeOk;
    ctrl.resumeCtx = rsmCtx;
    ctrl.reqCtx    = reqCur;
  end
  assign reqValid = reqActive;
  assign reqTier  = tierBit[reqCur];

  // the same context never issues in two consecutive cycles
  assert_rotation_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.issue |=> !(ctrl.issue && ctrl.issueCtx == $past(ctrl.issueCtx)));

  // a parked context can never reach writeback again
  assert_no_repark_R5: assert property (@(posedge clk) disable iff (!rstN)
    trapIn.park |-> !parked[trapIn.parkCtx]);

  // an offered request stays put until taken
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && ctrl.reqCtx == $past(ctrl.reqCtx)
                                 && reqTier == $past(reqTier)));
endmodule

// File: rtl/ilv_datapath.sv
module ilv_datapath
  import ilv_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              ctrl,
  input  logic [INSTR_W-1:0] fetchInstr,
  input  logic               rsmWrEn,
  input  logic [REG_W-1:0]   rsmWrIdx,
  input  logic [DATA_W-1:0]  rsmWrData,
  input  logic [PC_W-1:0]    rsmNextPc,
  output logic [PC_W-1:0]    fetchPc,
  output trap_t              trapOut,
  output logic               retireValid,
  output logic [CTX_W-1:0]   retireCtx,
  output logic [PC_W-1:0]    retirePc,
  output logic               retireWrEn,
  output logic [REG_W-1:0]   retireIdx,
  output logic [DATA_W-1:0]  retireData,
  output logic [PC_W-1:0]    reqPc,
  output logic [INSTR_W-1:0] reqInstr
);
  localparam int RF_DEPTH = NUM_CTX * NUM_REGS;

  typedef struct packed {
    logic               valid;
    logic [CTX_W-1:0]   ctx;
    logic [PC_W-1:0]    pc;
    logic [INSTR_W-1:0] instr;
  } stage_t;

  logic [DATA_W-1:0]  regFile   [RF_DEPTH];
  logic [PC_W-1:0]    pcArr     [NUM_CTX];
  logic [INSTR_W-1:0] trapInstr [NUM_CTX];

  stage_t dStg, eStg, wStg;
  logic [DATA_W-1:0] eOpA, eOpB;
  logic [DATA_W-1:0] exResult, wResult;
  logic [PC_W-1:0]   exNextPc, wNextPc;
  logic              exWrEn, exTrap, exTier, wWrEn, wTrap, wTier;

  assign fetchPc = pcArr[ctrl.issueCtx];

  // execute stage
  always_comb begin
    exResult = '0;
    exWrEn   = 1'b0;
    exTrap   = 1'b0;
    exTier   = 1'b0;
    exNextPc = eStg.pc + 1'b1;
    case (opcode_e'(eStg.instr[15:12]))
      OP_ADD:  begin exResult = eOpA + eOpB; exWrEn = 1'b1; end
      OP_SUB:  begin exResult = eOpA - eOpB; exWrEn = 1'b1; end
      OP_AND:  begin exResult = eOpA & eOpB; exWrEn = 1'b1; end
      OP_OR:   begin exResult = eOpA | eOpB; exWrEn = 1'b1; end
      OP_ADDI: begin
        exResult = eOpA + DATA_W'(eStg.instr[IMM_W-1:0]);
        exWrEn   = 1'b1;
      end
      OP_BEQZ: begin
        if (eOpA == '0)
          exNextPc = eStg.pc + {{(PC_W-IMM_W){eStg.instr[IMM_W-1]}}, eStg.instr[IMM_W-1:0]};
      end
      OP_IO:   begin exTrap = 1'b1; exTier = 1'b1; end
      default: begin exTrap = 1'b1; exTier = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dStg    <= '0;
      eStg    <= '0;
      wStg    <= '0;
      eOpA    <= '0;
      eOpB    <= '0;
      wResult <= '0;
      wNextPc <= '0;
      wWrEn   <= 1'b0;
      wTrap   <= 1'b0;
      wTier   <= 1'b0;
      for (int i = 0; i < RF_DEPTH; i++) regFile[i] <= '0;
      for (int c = 0; c < NUM_CTX; c++) begin
        pcArr[c]     <= '0;
        trapInstr[c] <= '0;
      end
    end else begin
      dStg    <= '{valid: ctrl.issue, ctx: ctrl.issueCtx, pc: fetchPc, instr: fetchInstr};
      eStg    <= dStg;
      eOpA    <= regFile[{dStg.ctx, dStg.instr[7:4]}];
      eOpB    <= regFile[{dStg.ctx, dStg.instr[3:0]}];
      wStg    <= eStg;
      wResult <= exResult;
      wNextPc <= exNextPc;
      wWrEn   <= exWrEn;
      wTrap   <= exTrap;
      wTier   <= exTier;
      if (retireValid) begin
        pcArr[wStg.ctx] <= wNextPc;
        if (wWrEn) regFile[{wStg.ctx, wStg.instr[11:8]}] <= wResult;
      end
      if (trapOut.park) trapInstr[wStg.ctx] <= wStg.instr;
      if (ctrl.resume) begin
        pcArr[ctrl.resumeCtx] <= rsmNextPc;
        if (rsmWrEn) regFile[{ctrl.resumeCtx, rsmWrIdx}] <= rsmWrData;
      end
    end
  end

  assign retireValid = wStg.valid && !wTrap;
  assign retireCtx   = wStg.ctx;
  assign retirePc    = wStg.pc;
  assign retireWrEn  = wWrEn;
  assign retireIdx   = wStg.instr[11:8];
  assign retireData  = wResult;

  assign trapOut.park     = wStg.valid && wTrap;
  assign trapOut.parkCtx  = wStg.ctx;
  assign trapOut.parkTier = wTier;

  assign reqPc    = pcArr[ctrl.reqCtx];
  assign reqInstr = trapInstr[ctrl.reqCtx];

  // adjacent occupied stages always belong to different contexts
  assert_distinct_de_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dStg.valid && eStg.valid) |-> dStg.ctx != eStg.ctx);
  assert_distinct_ew_R2: assert property (@(posedge clk) disable iff (!rstN)
    (eStg.valid && wStg.valid) |-> eStg.ctx != wStg.ctx);

  // a resume never lands on the context being written back
  assert_resume_apart_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.resume && wStg.valid) |-> ctrl.resumeCtx != wStg.ctx);
endmodule

// File: rtl/ilv_engine.sv
module ilv_engine
  import ilv_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  output logic               fetchValid,
  output logic [CTX_W-1:0]   fetchCtx,
  output logic [PC_W-1:0]    fetchPc,
  input  logic [INSTR_W-1:0] fetchInstr,
  output logic               retireValid,
  output logic [CTX_W-1:0]   retireCtx,
  output logic [PC_W-1:0]    retirePc,
  output logic               retireWrEn,
  output logic [REG_W-1:0]   retireIdx,
  output logic [DATA_W-1:0]  retireData,
  output logic               reqValid,
  input  logic               reqReady,
  output logic [CTX_W-1:0]   reqCtx,
  output logic [PC_W-1:0]    reqPc,
  output logic [INSTR_W-1:0] reqInstr,
  output logic               reqTier,
  input  logic               rsmValid,
  input  logic [CTX_W-1:0]   rsmCtx,
  input  logic               rsmWrEn,
  input  logic [REG_W-1:0]   rsmWrIdx,
  input  logic [DATA_W-1:0]  rsmWrData,
  input  logic [PC_W-1:0]    rsmNextPc
);
  ctrl_t ctrl;
  trap_t trap;

  ilv_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .trapIn   (trap),
    .reqReady (reqReady),
    .rsmValid (rsmValid),
    .rsmCtx   (rsmCtx),
    .ctrl     (ctrl),
    .reqValid (reqValid),
    .reqTier  (reqTier)
  );

  ilv_datapath u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .fetchInstr  (fetchInstr),
    .rsmWrEn     (rsmWrEn),
    .rsmWrIdx    (rsmWrIdx),
    .rsmWrData   (rsmWrData),
    .rsmNextPc   (rsmNextPc),
    .fetchPc     (fetchPc),
    .trapOut     (trap),
    .retireValid (retireValid),
    .retireCtx   (retireCtx),
    .retirePc    (retirePc),
    .retireWrEn  (retireWrEn),
    .retireIdx   (retireIdx),
    .retireData  (retireData),
    .reqPc       (reqPc),
    .reqInstr    (reqInstr)
  );

  assign fetchValid = ctrl.issue;
  assign fetchCtx   = ctrl.issueCtx;
  assign reqCtx     = ctrl.reqCtx;

  // tier chosen in control matches the opcode stored in datapath
  assert_tier_select_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqTier == (reqInstr[15:12] == OP_IO)));
endmodule

// File: tb/ilv_engine_bench.sv
module ilv_engine_bench;
  import ilv_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_WORDS = 32;
  localparam int NVEC = 10;
  // {instruction, expected written value} for context 0, pc 0..9
  localparam logic [47:0] VEC [NVEC] = '{
    {16'h4105, 32'h0000_0005}, {16'h421F, 32'h0000_0014},
    {16'h0312, 32'h0000_0019}, {16'h1412, 32'hFFFF_FFF1},
    {16'h2542, 32'h0000_0010}, {16'h3651, 32'h0000_0015},
    {16'h1700, 32'h0000_0000}, {16'h0111, 32'h0000_000A},
    {16'h4870, 32'h0000_0000}, {16'h3943, 32'hFFFF_FFF9}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic fetchValid, retireValid, retireWrEn, reqValid, reqReady, reqTier;
  logic rsmValid, rsmWrEn;
  logic [CTX_W-1:0] fetchCtx, retireCtx, reqCtx, rsmCtx;
  logic [PC_W-1:0] fetchPc, retirePc, reqPc, rsmNextPc;
  logic [INSTR_W-1:0] fetchInstr, reqInstr;
  logic [REG_W-1:0] retireIdx, rsmWrIdx;
  logic [DATA_W-1:0] retireData, rsmWrData;
  logic [15:0] prog [NUM_CTX*PROG_WORDS];

  int checks = 0, fails = 0, cyc = 0, nRet = 0;
  logic fV [64]; logic [CTX_W-1:0] fC [64]; logic [PC_W-1:0] fP [64];
  logic [PC_W-1:0] rPc [32]; logic rWr [32]; logic [REG_W-1:0] rIdx [32];
  logic [DATA_W-1:0] rData [32]; int rCyc [32];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign fetchInstr = prog[int'(fetchCtx)*PROG_WORDS + int'(fetchPc[4:0])];

  ilv_engine u_ilv_engine (.*);

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic waitCtx(input int c);
    for (int i = 0; i < 16 && int'(fetchCtx) != c; i++) tick();
  endtask

  task automatic waitReq();
    for (int i = 0; i < 400 && !reqValid; i++) tick();
  endtask

  task automatic acceptReq();
    reqReady = 1'b1; tick(); reqReady = 1'b0;
  endtask

  task automatic resume(input int c, input logic we, input logic [3:0] idx, input logic [31:0] d, input logic [15:0] npc);
    rsmValid = 1'b1; rsmCtx = CTX_W'(c); rsmWrEn = we; rsmWrIdx = idx; rsmWrData = d; rsmNextPc = npc;
    tick();
    rsmValid = 1'b0; rsmWrEn = 1'b0;
  endtask

  // monitor: samples just after each falling edge
  always begin
    @(negedge clk); #1;
    if (rstN) begin
      if (cyc < 64) begin fV[cyc] = fetchValid; fC[cyc] = fetchCtx; fP[cyc] = fetchPc; end
      if (retireValid && retireCtx == '0 && nRet < 32) begin
        rPc[nRet] = retirePc; rWr[nRet] = retireWrEn; rIdx[nRet] = retireIdx;
        rData[nRet] = retireData; rCyc[nRet] = cyc; nRet++;
      end
      cyc++;
    end
  end

  initial begin
    #(CLK_PERIOD*20000);
    fails++;
    $display("FAIL watchdog run did not complete");
    finishRun();
  end

  initial begin
    for (int i = 0; i < NUM_CTX*PROG_WORDS; i++) prog[i] = 16'h5000;
    for (int i = 0; i < NVEC; i++) prog[i] = VEC[i][47:32];
    prog[10] = 16'h5072; prog[11] = 16'h4A07; prog[12] = 16'h4A01;
    prog[13] = 16'hE000; prog[14] = 16'h0CB0; prog[15] = 16'h501F;
    prog[PROG_WORDS + 0] = 16'hF123;
    prog[2*PROG_WORDS + 0] = 16'h7000;
    reqReady = 1'b0; rsmValid = 1'b0; rsmCtx = '0; rsmWrEn = 1'b0;
    rsmWrIdx = '0; rsmWrData = '0; rsmNextPc = '0;

    repeat (3) tick();
    check("R8", "reset reqValid", 32'(reqValid), 32'd0);
    check("R8", "reset retireValid", 32'(retireValid), 32'd0);
    check("R8", "reset fetch slot", {fetchValid, 12'd0, fetchCtx, fetchPc}, {1'b1, 12'd0, 3'd0, 16'd0});
    @(negedge clk); rstN = 1'b1;
    repeat (20) tick();

    for (int i = 0; i < NUM_CTX; i++)
      check("R1", $sformatf("slot %0d issue", i), {fV[i], 28'd0, fC[i]}, {1'b1, 28'd0, 3'(i)});
    check("R1", "ctx0 second fetch pc", {fV[8], 15'd0, fP[8]}, {1'b1, 15'd0, 16'd1});
    check("R5", "ctx1 parked slot bubble", 32'(fV[9]), 32'd0);
    check("R5", "ctx2 parked slot bubble", 32'(fV[10]), 32'd0);
    check("R5", "ctx3 keeps issuing", {fV[11], 28'd0, fC[11]}, {1'b1, 28'd0, 3'd3});
    check("R2", "first retire cycle", 32'(rCyc[0]), 32'd3);
    check("R2", "second retire cycle", 32'(rCyc[1]), 32'd11);

    check("R6", "first request valid", 32'(reqValid), 32'd1);
    check("R6", "lowest context first", {reqTier, reqCtx, reqPc, reqInstr[11:0]}, {1'b0, 3'd1, 16'd0, 12'h123});
    repeat (3) tick();
    check("R6", "request held while not ready", {reqValid, reqCtx, reqInstr}, {1'b1, 3'd1, 16'hF123});
    acceptReq();
    waitReq();
    check("R6", "second request emulator tier", {reqValid, reqTier, reqCtx, reqInstr}, {1'b1, 1'b0, 3'd2, 16'h7000});
    acceptReq();

    resume(1, 1'b0, 4'd0, 32'd0, 16'd4);
    resume(3, 1'b1, 4'd5, 32'h55, 16'd9);
    tick();
    waitCtx(1);
    check("R7", "resumed ctx1 fetch", {fetchValid, 15'd0, fetchPc}, {1'b1, 15'd0, 16'd4});
    waitCtx(3);
    check("R7", "resume to running ctx3 ignored", {fetchValid, 15'd0, fetchPc}, {1'b1, 15'd0, 16'd0});

    waitReq();
    check("R6", "io request full-system tier", {reqValid, reqTier, reqCtx, reqPc}, {1'b1, 1'b1, 3'd0, 16'd13});
    check("R6", "io request word", 32'(reqInstr), 32'h0000_E000);
    acceptReq();
    waitCtx(0);
    check("R5", "ctx0 parked slot bubble", 32'(fetchValid), 32'd0);
    resume(0, 1'b1, 4'd11, 32'hDEAD_BEEF, 16'd14);
    repeat (40) tick();

    for (int i = 0; i < NVEC; i++)
      check("R3", $sformatf("vector %0d retire", i),
            {rWr[i], 11'd0, rIdx[i], rPc[i]}, {1'b1, 11'd0, VEC[i][43:40], 16'(i)});
    for (int i = 0; i < NVEC; i++)
      check("R3", $sformatf("vector %0d data", i), rData[i], VEC[i][31:0]);
    check("R4", "beqz zero retire no write", {15'd0, rWr[10], rPc[10]}, {15'd0, 1'b0, 16'd10});
    check("R4", "taken branch target", {rIdx[11], 12'd0, rPc[11]}, {4'd10, 12'd0, 16'd12});
    check("R4", "taken branch skipped pc11", rData[11], 32'd1);
    check("R7", "resume wrote register", {rPc[12], 12'd0, rIdx[12]}, {16'd14, 12'd0, 4'd12});
    check("R7", "resume data visible", rData[12], 32'hDEAD_BEEF);
    check("R5", "trap instruction did not retire", 32'(rPc[12]), 32'd14);
    check("R4", "nonzero beqz falls through", {15'd0, rWr[13], rPc[13]}, {15'd0, 1'b0, 16'd15});
    check("R4", "fall-through pc", 32'(rPc[14]), 32'd16);
    finishRun();
  end
endmodule